// File: doc/BRIEF.md
# Staggered Transmit Enable Sequencer

This block turns a transmit request level into three transmit-enable strobes that switch on one after another, so that a radio can be brought up in stages. The first strobe turns on as soon as the request is seen. The second strobe follows after a programmable gap. The third strobe follows the second after a second, independent gap. The first two strobes are meant to drive the radio's transmit-command pin and its power-amplifier enable. The third is a spare late stage.

Each gap is a 4-bit count of prescaled time steps. A step lasts either 20 or 40 input clocks, chosen by a single range-select input. Both gap fields and the range bit are captured when a sequence starts, so a new setting written during a transmission is used from the next transmission onward. When the request is removed, all three strobes switch off together and the sequencer waits for the next request.

Top module: `tx_stagger_seq`

## Requirements
- R1: While reset is held and right after it, enCmd, enAmp and enFinal are all 0.
- R2: When txReq is sampled high by a clock edge while the sequencer is idle, enCmd is 1 after that same edge. enAmp and enFinal are still 0 at that point.
- R3: With slowRange captured as 0, enAmp rises exactly G1*20 clock edges after the edge at which enCmd rose, where G1 is the captured gapFirst value (unsigned, 4 bits).
- R4: With slowRange captured as 1, the time step is 40 clocks, so enAmp rises exactly G1*40 edges after enCmd rises.
- R5: enFinal rises exactly G2*T edges after enAmp rises. G2 is the captured gapSecond value and T is the step length (20 or 40).
- R6: A gap value of 0 makes the next strobe rise on the edge immediately following the rise of the previous strobe.
- R7: When txReq is sampled low, all three strobes are 0 after that edge, whatever stage the sequence had reached. A later request restarts the sequence from enCmd, using the new settings.
- R8: gapFirst, gapSecond and slowRange are captured at the edge that starts a sequence. Changes to them while the sequence runs have no effect on its timing.
- R9: enFinal implies enAmp and enAmp implies enCmd at every cycle. Once risen, a strobe stays high for as long as txReq stays high.
- R10: The largest setting (gap 15 with a 40-clock step) gives a 600-clock gap with no wrap or early release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txReq | input | 1 | Transmit request level |
| gapFirst | input | 4 | Steps from enCmd rising to enAmp rising |
| gapSecond | input | 4 | Steps from enAmp rising to enFinal rising |
| slowRange | input | 1 | Step length select: 0 gives 20 clocks, 1 gives 40 clocks |
| enCmd | output | 1 | First-stage enable (transmit command) |
| enAmp | output | 1 | Second-stage enable (power amplifier) |
| enFinal | output | 1 | Third-stage enable |

## Verification
The assertions assume that txReq is a synchronous level that meets setup to clk. They also assume that the gap and range inputs are stable at the edge that starts a sequence. Nothing in them depends on those inputs being steady at any other time. The stimulus drives every input on the falling clock edge, so each value is settled well before the rising edge that samples it. Gap and range changes are made only after the starting edge, or while the sequencer is idle. This keeps the mid-sequence test of R8 inside those assumptions while still changing the inputs during a live sequence.

// File: rtl/tx_stagger_pkg.sv
package tx_stagger_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GAP1 = 2'd1,
    SEQ_GAP2 = 2'd2,
    SEQ_HOLD = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch gap fields and range bit
    logic armGap;     // restart prescaler and load a gap count
    logic useSecond;  // armGap loads the second gap instead of the first
    logic count;      // advance the gap timer this cycle
  } seqCmd_t;

endpackage

// File: rtl/tx_stagger_dp.sv
module tx_stagger_dp
  import tx_stagger_pkg::*;
#(
  parameter int GAP_W     = 4,
  parameter int STEP_FAST = 20,
  parameter int STEP_SLOW = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GAP_W-1:0] gapFirst,
  input  logic [GAP_W-1:0] gapSecond,
  input  logic             slowRange,
  input  seqCmd_t          cmd,
  output logic             gapDone
);

  localparam int STEP_MAX = (STEP_SLOW > STEP_FAST) ? STEP_SLOW : STEP_FAST;
  localparam int PRE_W    = $clog2(STEP_MAX);
  localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'(STEP_FAST - 1);
  localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'(STEP_SLOW - 1);

  logic [GAP_W-1:0] gap1Q, gap2Q;
  logic             slowQ;
  logic [PRE_W-1:0] prescQ;
  logic [GAP_W-1:0] stepsLeftQ;
  logic [PRE_W-1:0] stepLast;
  logic             stepWrap;
  logic [GAP_W-1:0] armValue;

  assign stepLast = slowQ ? SLOW_LAST : FAST_LAST;
  assign stepWrap = (prescQ == stepLast);
  assign gapDone  = (stepsLeftQ == '0) ||
                    ((stepsLeftQ == GAP_W'(1)) && stepWrap);

  // At the start edge the captured copy is not loaded yet, so use the input
  always_comb begin
    if (cmd.useSecond)    armValue = gap2Q;
    else if (cmd.capture) armValue = gapFirst;
    else                  armValue = gap1Q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap1Q <= '0;
      gap2Q <= '0;
      slowQ <= 1'b0;
    end else if (cmd.capture) begin
      gap1Q <= gapFirst;
      gap2Q <= gapSecond;
      slowQ <= slowRange;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescQ     <= '0;
      stepsLeftQ <= '0;
    end else if (cmd.armGap) begin
      prescQ     <= '0;
      stepsLeftQ <= armValue;
    end else if (cmd.count && (stepsLeftQ != '0)) begin
      if (stepWrap) begin
        prescQ <= '0;
        if (stepsLeftQ > GAP_W'(1)) stepsLeftQ <= stepsLeftQ - GAP_W'(1);
      end else begin
        prescQ <= prescQ + PRE_W'(1);
      end
    end
  end

  // Prescaler never passes the selected step length (R4, R10)
  assert_presc_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    prescQ <= stepLast);

  // Without a new arm the remaining step count never grows (R3)
  assert_steps_monotone_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.armGap |=> stepsLeftQ <= $past(stepsLeftQ));

  // Captured settings are held while no sequence starts (R8)
  assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.capture |=> ($stable(gap1Q) && $stable(gap2Q) && $stable(slowQ)));

endmodule

// File: rtl/tx_stagger_ctrl.sv
module tx_stagger_ctrl
  import tx_stagger_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txReq,
  input  logic    gapDone,
  output seqCmd_t cmd,
  output logic    enCmd,
  output logic    enAmp,
  output logic    enFinal
);

  seqState_t stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    cmd       = '0;
    if (!txReq) begin
      stateNext = SEQ_IDLE;
    end else begin
      unique case (stateQ)
        SEQ_IDLE: begin
          cmd.capture = 1'b1;
          cmd.armGap  = 1'b1;
          stateNext   = SEQ_GAP1;
        end
        SEQ_GAP1: begin
          if (gapDone) begin
            cmd.armGap    = 1'b1;
            cmd.useSecond = 1'b1;
            stateNext     = SEQ_GAP2;
          end else begin
            cmd.count = 1'b1;
          end
        end
        SEQ_GAP2: begin
          if (gapDone) stateNext = SEQ_HOLD;
          else         cmd.count = 1'b1;
        end
        SEQ_HOLD: stateNext = SEQ_HOLD;
        default:  stateNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEQ_IDLE;
    else       stateQ <= stateNext;
  end

  assign enCmd   = (stateQ != SEQ_IDLE);
  assign enAmp   = (stateQ == SEQ_GAP2) || (stateQ == SEQ_HOLD);
  assign enFinal = (stateQ == SEQ_HOLD);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !enCmd) |=> (enCmd && !enAmp && !enFinal));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !txReq |=> (!enCmd && !enAmp && !enFinal));

  assert_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!enFinal || enAmp) && (!enAmp || enCmd));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && enAmp) |=> enAmp);

  assert_one_stage_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enFinal) |-> $past(enAmp));

endmodule

// File: rtl/tx_stagger_seq.sv
module tx_stagger_seq
  import tx_stagger_pkg::*;
#(
  parameter int GAP_W     = 4,
  parameter int STEP_FAST = 20,
  parameter int STEP_SLOW = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txReq,
  input  logic [GAP_W-1:0] gapFirst,
  input  logic [GAP_W-1:0] gapSecond,
  input  logic             slowRange,
  output logic             enCmd,
  output logic             enAmp,
  output logic             enFinal
);

  seqCmd_t seqCmd;
  logic    gapDone;

  tx_stagger_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .txReq   (txReq),
    .gapDone (gapDone),
    .cmd     (seqCmd),
    .enCmd   (enCmd),
    .enAmp   (enAmp),
    .enFinal (enFinal)
  );

  tx_stagger_dp #(
    .GAP_W     (GAP_W),
    .STEP_FAST (STEP_FAST),
    .STEP_SLOW (STEP_SLOW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .gapFirst  (gapFirst),
    .gapSecond (gapSecond),
    .slowRange (slowRange),
    .cmd       (seqCmd),
    .gapDone   (gapDone)
  );

endmodule

// File: tb/tx_stagger_seq_test.sv
`timescale 1ns/1ps
module tx_stagger_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txReq = 1'b0;
  logic [3:0] gapFirst = '0;
  logic [3:0] gapSecond = '0;
  logic       slowRange = 1'b0;
  logic       enCmd, enAmp, enFinal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_stagger_seq uut (
    .clk(clk), .rstN(rstN), .txReq(txReq),
    .gapFirst(gapFirst), .gapSecond(gapSecond), .slowRange(slowRange),
    .enCmd(enCmd), .enAmp(enAmp), .enFinal(enFinal)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Count falling edges until sig is high; a rise at edge n is seen at the n-th falling edge
  task automatic waitRise(input int which, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!((which == 2) ? enAmp : enFinal) && n < limit);
  endtask

  function automatic int gapLen(input int g, input bit slow);
    return (g == 0) ? 1 : g * (slow ? 40 : 20);
  endfunction

  // Start a sequence and check each stage and then the release
  task automatic runSeq(input string tag, input int g1, input int g2, input bit slow);
    int n;
    @(negedge clk);
    gapFirst = 4'(g1); gapSecond = 4'(g2); slowRange = slow; txReq = 1'b1;
    @(negedge clk);
    checkEq({tag, " R2 enCmd"}, enCmd, 1);
    checkEq({tag, " R2 enAmp low"}, enAmp, 0);
    waitRise(2, 2000, n);
    checkEq({tag, " R3/R4/R6 first gap"}, n, gapLen(g1, slow));
    checkEq({tag, " R9 enFinal low"}, enFinal, 0);
    waitRise(3, 2000, n);
    checkEq({tag, " R5/R6 second gap"}, n, gapLen(g2, slow));
    repeat (5) @(negedge clk);
    checkEq({tag, " R9 all held"}, {enCmd, enAmp, enFinal}, 3'b111);
    txReq = 1'b0;
    @(negedge clk);
    checkEq({tag, " R7 released"}, {enCmd, enAmp, enFinal}, 3'b000);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1 in reset", {enCmd, enAmp, enFinal}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkEq("R1 after reset", {enCmd, enAmp, enFinal}, 0);
  endtask

  task automatic testMidChange();
    int n;
    @(negedge clk);
    gapFirst = 4'd2; gapSecond = 4'd1; slowRange = 1'b0; txReq = 1'b1;
    @(negedge clk);
    gapFirst = 4'd9; gapSecond = 4'd7; slowRange = 1'b1;
    waitRise(2, 2000, n);
    checkEq("R8 first gap unchanged", n, 40);
    waitRise(3, 2000, n);
    checkEq("R8 second gap unchanged", n, 20);
    txReq = 1'b0;
    @(negedge clk);
    checkEq("R8 released", {enCmd, enAmp, enFinal}, 0);
  endtask

  task automatic testDropMidGap();
    int n;
    @(negedge clk);
    gapFirst = 4'd5; gapSecond = 4'd3; slowRange = 1'b1; txReq = 1'b1;
    repeat (10) @(negedge clk);
    checkEq("R7 mid-gap enCmd", enCmd, 1);
    txReq = 1'b0;
    @(negedge clk);
    checkEq("R7 mid-gap release", {enCmd, enAmp, enFinal}, 0);
    gapFirst = 4'd1; gapSecond = 4'd2; slowRange = 1'b0; txReq = 1'b1;
    @(negedge clk);
    checkEq("R7 restart enCmd", enCmd, 1);
    waitRise(2, 2000, n);
    checkEq("R7 restart first gap", n, 20);
    waitRise(3, 2000, n);
    checkEq("R7 restart second gap", n, 40);
    txReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    testReset();
    runSeq("fast", 3, 2, 1'b0);
    runSeq("slow", 2, 3, 1'b1);
    runSeq("zero", 0, 0, 1'b0);
    runSeq("zero-first", 0, 4, 1'b1);
    runSeq("R10 max", 15, 15, 1'b1);
    testMidChange();
    testDropMidGap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule